// File: doc/BRIEF.md
# Grouped GPIO Interrupt Controller

This block turns activity on banks of general-purpose input pins into one interrupt request for a processor. The pins are arranged in groups of up to eight. Every pin has its own trigger selection: active-low level, active-high level, falling edge, rising edge or either edge. When a pin's trigger fires, a pending flag for that pin is latched. Software clears pending flags by writing ones, and it can block any pin from reaching the shared request line with a per-pin mask bit.

Pins arrive asynchronously. Each one is brought into the clock domain through two flip-flops before any detection logic sees it. Software reaches the block through a plain register port. Each access presents a byte address together with a write enable and write data, or with a read enable. The read value appears on the cycle after the read enable. Three banks of registers sit behind the port, holding trigger codes, masks and pending flags, with one word per group in each bank.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: In a group's trigger word, pin n uses bits [4n+2:4n]. The codes are 0 for low level, 1 for high level, 2 for falling edge, 3 for rising edge and 4 for either edge. Bit 4n+3 always reads back as 0.
- R2: The trigger bank starts at byte 0x700, the mask bank at 0x900 and the pending bank at 0xA00. Group g's word sits at base + 4g. Read data is presented on regRdata in the cycle after regRe.
- R3: In the three edge modes, a matching transition of the synchronized pin sets the pending bit. The bit then stays set until software acknowledges it.
- R4: In the two level modes, the pending bit is set on every cycle that the level is active. If a set and an acknowledge fall in the same cycle, the set wins, so an acknowledge only takes effect once the level is gone.
- R5: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged.
- R6: A pending bit is set whenever its trigger occurs, whatever the state of its mask bit.
- R7: irqOut is high exactly when at least one pin, in any group, has its pending bit at 1 and its mask bit at 0. A mask bit of 1 blocks that pin.
- R8: After reset every mask bit is 1, every pending bit is 0 and every trigger field is 0. No pending bit is set while the input synchronizers are still filling after reset.
- R9: Trigger codes 5, 6 and 7 never set a pending bit.
- R10: Bits above the valid pins in the mask and pending words, unused addresses, misaligned addresses and group indices beyond the last group all read as 0. Writes to any of them change nothing.
- R11: If a pin changes just after a clock edge, the resulting pending bit, and irqOut when the pin is unmasked, rises at the third following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pinIn | input | NUM_GROUPS*PINS_PER_GROUP | Asynchronous pin inputs; group g, pin n is bit g*PINS_PER_GROUP+n |
| regAddr | input | ADDR_W | Byte address of the register access |
| regWdata | input | DATA_W | Write data |
| regWe | input | 1 | Write strobe |
| regRe | input | 1 | Read strobe |
| regRdata | output | DATA_W | Read data, valid the cycle after regRe, zero otherwise |
| irqOut | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is the race in the level modes, where an acknowledge lands while the level is still active and the set has to win. The bench drives this directly. With every group in a level mode and the pins held at one pattern, it clears all pending words, then switches the pins to a second pattern. It then reads back the union of the two active sets, clears once more and expects only the second pattern's active pins to remain. The same two-pattern sweep is run for every one of the eight code values on all pins. For each code the expected words are computed arithmetically from the two patterns.

// File: rtl/gic_pkg.sv
package gic_pkg;

  localparam int GRP_IDX_W = 8;

  typedef enum logic [2:0] {
    TRIG_LOW  = 3'd0,
    TRIG_HIGH = 3'd1,
    TRIG_FALL = 3'd2,
    TRIG_RISE = 3'd3,
    TRIG_BOTH = 3'd4
  } trig_e;

  typedef enum logic [1:0] {
    BANK_NONE = 2'd0,
    BANK_CFG  = 2'd1,
    BANK_MASK = 2'd2,
    BANK_PEND = 2'd3
  } bank_e;

  // Strobes from the control module to the datapath.
  typedef struct packed {
    logic                 cfgWr;
    logic                 maskWr;
    logic                 pendWr;
    logic                 rdEn;
    bank_e                rdBank;
    logic [GRP_IDX_W-1:0] group;
    logic                 detectEn;
  } strobe_t;

  // Trigger decision for one pin from its code, current and previous sample.
  function automatic logic trig_hit(input logic [2:0] code, input logic cur,
                                    input logic prev);
    logic hit;
    case (code)
      TRIG_LOW:  hit = !cur;
      TRIG_HIGH: hit = cur;
      TRIG_FALL: hit = prev && !cur;
      TRIG_RISE: hit = !prev && cur;
      TRIG_BOTH: hit = prev ^ cur;
      default:   hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/gic_ctrl.sv
module gic_ctrl
  import gic_pkg::*;
#(
  parameter int              ADDR_W      = 12,
  parameter int              NUM_GROUPS  = 4,
  parameter logic [ADDR_W-1:0] CFG_BASE  = 12'h700,
  parameter logic [ADDR_W-1:0] MASK_BASE = 12'h900,
  parameter logic [ADDR_W-1:0] PEND_BASE = 12'hA00,
  parameter int              WARM_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic              regRe,
  output strobe_t           strb
);

  localparam int NUM_BANKS = 3;
  localparam int SPAN      = NUM_GROUPS * 4;
  localparam int WARM_W    = $clog2(WARM_CYCLES + 1);
  localparam logic [ADDR_W-1:0] BANK_BASE [NUM_BANKS] = '{CFG_BASE, MASK_BASE, PEND_BASE};

  logic [NUM_BANKS-1:0] bankHit;
  logic [ADDR_W-1:0]    bankOff [NUM_BANKS];

  // One decoder per bank: aligned, inside the group span.
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bankOff[b] = regAddr - BANK_BASE[b];
    assign bankHit[b] = (regAddr >= BANK_BASE[b]) &&
                        (bankOff[b] < ADDR_W'(SPAN)) &&
                        (bankOff[b][1:0] == 2'b00);
  end

  bank_e                selBank;
  logic [ADDR_W-1:0]    selOff;

  always_comb begin
    selBank = BANK_NONE;
    selOff  = '0;
    if (bankHit[0]) begin
      selBank = BANK_CFG;
      selOff  = bankOff[0];
    end else if (bankHit[1]) begin
      selBank = BANK_MASK;
      selOff  = bankOff[1];
    end else if (bankHit[2]) begin
      selBank = BANK_PEND;
      selOff  = bankOff[2];
    end
  end

  // Hold off detection until the synchronizer and history flops are filled.
  logic [WARM_W-1:0] warmCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warmCnt <= '0;
    end else if (warmCnt != WARM_W'(WARM_CYCLES)) begin
      warmCnt <= warmCnt + 1'b1;
    end
  end

  always_comb begin
    strb          = '0;
    strb.cfgWr    = regWe && (selBank == BANK_CFG);
    strb.maskWr   = regWe && (selBank == BANK_MASK);
    strb.pendWr   = regWe && (selBank == BANK_PEND);
    strb.rdEn     = regRe;
    strb.rdBank   = selBank;
    strb.group    = GRP_IDX_W'(selOff >> 2);
    strb.detectEn = (warmCnt == WARM_W'(WARM_CYCLES));
  end

  // R2: a single write reaches at most one bank.
  p_one_bank_r2 : assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.cfgWr, strb.maskWr, strb.pendWr}));

  // R8: detection stays off in the first cycle after reset.
  p_warm_after_reset_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> !strb.detectEn);

endmodule

// File: rtl/gic_datapath.sv
module gic_datapath
  import gic_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  parameter int PINS       = 8,
  parameter int DATA_W     = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_GROUPS*PINS-1:0] pinIn,
  input  strobe_t                    strb,
  input  logic [DATA_W-1:0]          regWdata,
  output logic [DATA_W-1:0]          regRdata,
  output logic                       irqOut
);

  localparam int NPIN = NUM_GROUPS * PINS;

  function automatic logic [DATA_W-1:0] cfgKeepMask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < PINS; i++) m[4*i +: 3] = 3'b111;
    return m;
  endfunction

  localparam logic [DATA_W-1:0] CFG_KEEP = cfgKeepMask();

  // Input synchronizer and one-cycle history.
  logic [NPIN-1:0] syncA, syncB, prevB;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncA <= '0;
      syncB <= '0;
      prevB <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
      prevB <= syncB;
    end
  end

  logic [NPIN-1:0]            trigHit, pendFlat, maskFlat, clrFlat;
  logic [NUM_GROUPS*DATA_W-1:0] cfgFlat;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    logic              selThis;
    logic [DATA_W-1:0] cfgR;
    logic [PINS-1:0]   maskR, pendR, clrVec, setVec;

    assign selThis = (strb.group == GRP_IDX_W'(g));
    assign clrVec  = (strb.pendWr && selThis) ? regWdata[PINS-1:0] : '0;
    assign setVec  = strb.detectEn ? trigHit[g*PINS +: PINS] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfgR <= '0;
      end else if (strb.cfgWr && selThis) begin
        cfgR <= regWdata & CFG_KEEP;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        maskR <= '1;
      end else if (strb.maskWr && selThis) begin
        maskR <= regWdata[PINS-1:0];
      end
    end

    // Set wins over a same-cycle acknowledge.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pendR <= '0;
      end else begin
        pendR <= (pendR & ~clrVec) | setVec;
      end
    end

    for (genvar i = 0; i < PINS; i++) begin : g_pin
      localparam int P = g * PINS + i;
      assign trigHit[P] = trig_hit(cfgR[4*i +: 3], syncB[P], prevB[P]);

      // R4: a trigger seen with detection on always leaves the bit set.
      p_set_wins_r4 : assert property (@(posedge clk) disable iff (!rst_n)
        (strb.detectEn && trigHit[P]) |=> pendFlat[P]);
    end

    assign pendFlat[g*PINS +: PINS]     = pendR;
    assign maskFlat[g*PINS +: PINS]     = maskR;
    assign clrFlat[g*PINS +: PINS]      = clrVec;
    assign cfgFlat[g*DATA_W +: DATA_W]  = cfgR;
  end

  // Read mux and registered read data.
  logic [DATA_W-1:0] rdVal;

  always_comb begin
    rdVal = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (strb.group == GRP_IDX_W'(g)) begin
        case (strb.rdBank)
          BANK_CFG:  rdVal = cfgFlat[g*DATA_W +: DATA_W];
          BANK_MASK: rdVal = DATA_W'(maskFlat[g*PINS +: PINS]);
          BANK_PEND: rdVal = DATA_W'(pendFlat[g*PINS +: PINS]);
          default:   rdVal = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regRdata <= '0;
    end else begin
      regRdata <= strb.rdEn ? rdVal : '0;
    end
  end

  assign irqOut = |(pendFlat & ~maskFlat);

  // R3: a pending bit only drops through an acknowledge.
  p_pend_sticky_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    &(~($past(pendFlat) & ~$past(clrFlat)) | pendFlat));

  // R8: no new pending bit while detection is held off.
  p_quiet_warmup_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    !strb.detectEn |=> ((pendFlat & ~$past(pendFlat)) == '0));

  // R10: a read outside the map returns zero.
  p_unused_read_r10 : assert property (@(posedge clk) disable iff (!rst_n)
    (strb.rdEn && strb.rdBank == BANK_NONE) |=> (regRdata == '0));

  // R7: the request needs at least one pending bit.
  p_irq_needs_pend_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    irqOut |-> (|pendFlat));

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gic_pkg::*;
#(
  parameter int NUM_GROUPS     = 4,
  parameter int PINS_PER_GROUP = 8,
  parameter int ADDR_W         = 12,
  parameter int DATA_W         = 32
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [NUM_GROUPS*PINS_PER_GROUP-1:0] pinIn,
  input  logic [ADDR_W-1:0]                    regAddr,
  input  logic [DATA_W-1:0]                    regWdata,
  input  logic                                 regWe,
  input  logic                                 regRe,
  output logic [DATA_W-1:0]                    regRdata,
  output logic                                 irqOut
);

  strobe_t strb;

  gic_ctrl #(
    .ADDR_W     (ADDR_W),
    .NUM_GROUPS (NUM_GROUPS),
    .CFG_BASE   (ADDR_W'(12'h700)),
    .MASK_BASE  (ADDR_W'(12'h900)),
    .PEND_BASE  (ADDR_W'(12'hA00)),
    .WARM_CYCLES(3)
  ) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .regAddr(regAddr),
    .regWe  (regWe),
    .regRe  (regRe),
    .strb   (strb)
  );

  gic_datapath #(
    .NUM_GROUPS(NUM_GROUPS),
    .PINS      (PINS_PER_GROUP),
    .DATA_W    (DATA_W)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .pinIn   (pinIn),
    .strb    (strb),
    .regWdata(regWdata),
    .regRdata(regRdata),
    .irqOut  (irqOut)
  );

endmodule

// File: tb/gpio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_tb;

  localparam int NG   = 4;
  localparam int NP   = 8;
  localparam int NPIN = NG * NP;
  localparam logic [11:0] CFG_B  = 12'h700;
  localparam logic [11:0] MASK_B = 12'h900;
  localparam logic [11:0] PEND_B = 12'hA00;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NPIN-1:0] pins;
  logic [11:0]     addr;
  logic [31:0]     wdata;
  logic            we, re;
  logic [31:0]     rdata;
  logic            irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  gpio_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .pinIn(pins), .regAddr(addr),
    .regWdata(wdata), .regWe(we), .regRe(re), .regRdata(rdata), .irqOut(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; re = 1'b1;
    @(negedge clk);
    re = 1'b0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] cfgAll(input int m);
    logic [31:0] v = '0;
    for (int i = 0; i < NP; i++) v[4*i +: 3] = 3'(m);
    return v;
  endfunction

  task automatic clearAll();
    for (int g = 0; g < NG; g++) wr(PEND_B + 12'(4*g), 32'hFF);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, patA, patB, exp1, exp2;
    rst_n = 1'b0; pins = '1; addr = '0; wdata = '0; we = 1'b0; re = 1'b0;
    idle(4);
    rst_n = 1'b1;
    idle(6);

    // R8: reset state; pins high with low-level code must not trigger during warm-up
    for (int g = 0; g < NG; g++) begin
      rd(CFG_B + 12'(4*g), v);  check("R8 cfg reset", v, 32'h0);
      rd(MASK_B + 12'(4*g), v); check("R8 mask reset", v, 32'hFF);
      rd(PEND_B + 12'(4*g), v); check("R8 pend reset", v, 32'h0);
    end
    check("R8 irq reset", 32'(irq), 32'h0);

    // R1 / R10: unused bits and addresses
    wr(CFG_B + 12'h4, 32'hFFFF_FFFF);
    rd(CFG_B + 12'h4, v);  check("R1 nibble bit3 zero", v, 32'h7777_7777);
    wr(MASK_B, 32'hFFFF_FF00);
    rd(MASK_B, v);         check("R10 mask upper bits", v, 32'h0000_0000);
    wr(MASK_B, 32'hFFFF_FFFF);
    rd(MASK_B, v);         check("R10 mask upper bits set", v, 32'hFF);
    wr(12'h800, 32'h0);
    wr(MASK_B + 12'h10, 32'h0);
    wr(MASK_B + 12'h1, 32'h0);
    rd(MASK_B, v);         check("R10 stray writes ignored", v, 32'hFF);
    rd(12'h800, v);        check("R10 gap read", v, 32'h0);
    rd(CFG_B + 12'h10, v); check("R10 group out of range", v, 32'h0);
    rd(MASK_B + 12'h2, v); check("R10 misaligned read", v, 32'h0);
    rd(PEND_B + 12'hC, v); check("R2 last pend word", v, 32'h0);

    // R1 R3 R4 R5 R6 R9: all codes on all pins, two-pattern sweep
    patA = 32'hA5C3_0F96;
    patB = 32'h3C5A_F0E1;
    for (int m = 0; m < 8; m++) begin
      pins = patA;
      idle(6);
      for (int g = 0; g < NG; g++) wr(CFG_B + 12'(4*g), cfgAll(m));
      idle(6);
      clearAll();
      pins = patB;
      idle(6);
      case (m)
        0: begin exp1 = ~patA | ~patB; exp2 = ~patB; end
        1: begin exp1 = patA | patB;   exp2 = patB;  end
        2: begin exp1 = patA & ~patB;  exp2 = '0;    end
        3: begin exp1 = ~patA & patB;  exp2 = '0;    end
        4: begin exp1 = patA ^ patB;   exp2 = '0;    end
        default: begin exp1 = '0;      exp2 = '0;    end
      endcase
      for (int g = 0; g < NG; g++) begin
        rd(PEND_B + 12'(4*g), v);
        if (m < 2)      check("R4 level pend after ack", v, 32'(exp1[8*g +: 8]));
        else if (m < 5) check("R3 edge pend", v, 32'(exp1[8*g +: 8]));
        else            check("R9 reserved code", v, 32'(exp1[8*g +: 8]));
      end
      wr(PEND_B, 32'h0);
      rd(PEND_B, v); check("R5 write zero keeps", v, 32'(exp1[7:0]));
      check("R6 masked pend irq low", 32'(irq), 32'h0);
      clearAll();
      idle(6);
      for (int g = 0; g < NG; g++) begin
        rd(PEND_B + 12'(4*g), v);
        if (m < 2) check("R4 level remains", v, 32'(exp2[8*g +: 8]));
        else       check("R5 ack clears", v, 32'(exp2[8*g +: 8]));
      end
    end

    // R6 R7: masking only gates the output
    for (int g = 0; g < NG; g++) wr(CFG_B + 12'(4*g), cfgAll(3));
    pins = '0;
    idle(6);
    clearAll();
    pins[21] = 1'b1;
    idle(6);
    rd(PEND_B + 12'h8, v); check("R6 latched while masked", v, 32'h20);
    check("R7 irq masked", 32'(irq), 32'h0);
    wr(MASK_B + 12'h8, 32'hDF);
    check("R7 irq unmasked", 32'(irq), 32'h1);
    wr(MASK_B + 12'h8, 32'hFE);
    check("R7 other pin unmasked", 32'(irq), 32'h0);
    wr(MASK_B + 12'h8, 32'hDF);
    wr(PEND_B + 12'h8, 32'h20);
    check("R5 ack drops irq", 32'(irq), 32'h0);

    // R11: latency from pin to request
    wr(MASK_B + 12'h8, 32'hFF);
    wr(MASK_B, 32'hFE);
    clearAll();
    check("R11 idle before", 32'(irq), 32'h0);
    @(negedge clk); pins[0] = 1'b1;
    @(negedge clk); check("R11 after one edge", 32'(irq), 32'h0);
    @(negedge clk); check("R11 after two edges", 32'(irq), 32'h0);
    @(negedge clk); check("R11 after three edges", 32'(irq), 32'h1);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule